// File: doc/BRIEF.md
# I2C Slave Release and Wait-Cancel Control

This block is the control and status core of the slave side of an I2C controller. It holds the enable bit, the start and stop request bits and a set of bus status flags. It also drives the open-drain pad enables for SCL and SDA. A bit engine outside this block does the shifting. It reports bus events on single-cycle strobes: start, stop, address match with the read/write bit, extension code, acknowledge seen, master mode won, ninth-clock wait and byte complete. Software reaches the block through a small register port with a write strobe and a read mux that has no delay.

Software has two commands that clear themselves. The release command drops out of the current transfer. It frees both lines and puts the block into a sticky standby. Standby ends only when a stop condition is seen, or when an address match or extension code arrives after a start condition. The wait-cancel command ends a clock-stretching wait at the ninth clock. When the block is transmitting, wait-cancel also frees SDA and leaves transmit mode. Software should issue a release right after enabling the block, because enabling it onto a bus that looks like a start (SCL high, SDA low, filter on) records a start at once.

Top module: `i2c_relw_ctrl`

## Requirements
- R1: After reset, the control register (address 0: bit 7 enable, bit 6 release, bit 5 wait-cancel, bit 4 filter, bit 1 start request, bit 0 stop request) and the status register (address 1: bit 0 start seen, bit 1 stop seen, bit 2 address match, bit 3 extension code, bit 4 transmit, bit 5 ack seen, bit 6 master, bit 7 standby) read 0, and both pad enables are 0.
- R2: Clearing the enable bit clears every status flag, both request bits and both pad enables on that same edge. While the block is disabled, bus events and the release and wait-cancel commands have no effect.
- R3: A release command, issued while the block is enabled, sets standby. It clears the start seen, address match, extension code, transmit, ack seen and master flags, the start and stop request bits, and both pad enables. It leaves the stop seen flag unchanged.
- R4: The release and wait-cancel bits always read back as 0.
- R5: A stop event ends standby and sets the stop seen flag.
- R6: While in standby, an address match or extension code ends standby only if a start event has been seen since the release. Without that start it is ignored.
- R7: While in standby, the wait, byte complete, ack and master events are ignored, and both pad enables stay 0.
- R8: A wait-cancel command while a wait is pending frees SCL and SDA. In transmit mode it also clears the transmit flag. In receive mode the transmit flag stays 0.
- R9: A wait-cancel command with no wait pending changes no flag and no pad enable.
- R10: Enabling the block with filter = 1 while SCL is high and SDA is low sets the start seen flag on the enabling edge. With filter = 0 it does not.
- R11: In a cycle that carries a release or wait-cancel command, all bus event inputs of that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| scl_in | input | 1 | Filtered SCL level |
| sda_in | input | 1 | Filtered SDA level |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_match | input | 1 | Own address matched strobe |
| ev_rw | input | 1 | Read/write bit of the match (1 = slave transmits) |
| ev_ext | input | 1 | Extension code received strobe |
| ev_ack | input | 1 | Acknowledge seen strobe |
| ev_master | input | 1 | Master mode won strobe |
| ev_wait | input | 1 | Ninth-clock wait begins |
| ev_data | input | 1 | Byte complete; hold SDA low |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The assertions check the following on every cycle. A disabled block shows empty status and free pads. Standby never drives a pad. The command bits read as 0. A release leaves the block in standby with free pads. A wait-cancel in transmit drops the transmit flag and frees both lines. A wait-cancel with no wait pending leaves the status unchanged. Only the bench scenarios can show the rules that depend on history: standby exits only through a stop, or through a match or extension code after a start; the enable-time false start depends on the filter and the line levels; a command in the same cycle as a bus event wins over it. The bench covers these with a behavioural model compared on every clock, plus directed reads with hand-computed values.

// File: rtl/i2c_relw_pkg.sv
// Shared constants for the slave release/wait control core.
// Assumes an 8-bit register view. The bit positions are software-visible.
package i2c_relw_pkg;
    localparam int REG_W  = 8;
    // control register bit positions
    localparam int C_EN   = 7;
    localparam int C_REL  = 6;
    localparam int C_WCAN = 5;
    localparam int C_FILT = 4;
    localparam int C_STT  = 1;
    localparam int C_SPT  = 0;
    // status register bit positions
    localparam int S_STD  = 0;
    localparam int S_SPD  = 1;
    localparam int S_MAT  = 2;
    localparam int S_EXT  = 3;
    localparam int S_TRC  = 4;
    localparam int S_ACK  = 5;
    localparam int S_MST  = 6;
    localparam int S_SBY  = 7;
endpackage

// File: rtl/relw_ctrl_regs.sv
// Control register: enable, filter, start/stop requests, and the decode of
// the self-clearing release and wait-cancel commands.
// Assumes that bus events arrive already qualified by the enable and command masks.
module relw_ctrl_regs
    import i2c_relw_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              acc_master,
    input  logic              acc_stop,
    output logic              en_q,
    output logic              en_d,
    output logic              en_rise,
    output logic              filt_q,
    output logic              stt_q,
    output logic              spt_q,
    output logic              cmd_rel,
    output logic              cmd_wcan
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);

    logic wr_ctrl;

    // Decode a control write and the commands, which count only while already enabled.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == CA);
        en_d     = wr_ctrl ? wr_data[C_EN] : en_q;
        en_rise  = wr_ctrl && !en_q && wr_data[C_EN];
        cmd_rel  = wr_ctrl && en_q && wr_data[C_REL];
        cmd_wcan = wr_ctrl && en_q && wr_data[C_WCAN];
    end

    // Store enable and filter; keep the request bits until an event or a release clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            filt_q <= 1'b0;
            stt_q  <= 1'b0;
            spt_q  <= 1'b0;
        end else begin
            en_q <= en_d;
            if (wr_ctrl) filt_q <= wr_data[C_FILT];
            if (!en_d || cmd_rel) begin
                stt_q <= 1'b0;
                spt_q <= 1'b0;
            end else begin
                stt_q <= (stt_q && !acc_master) || (wr_ctrl && wr_data[C_STT]);
                spt_q <= (spt_q && !acc_stop)   || (wr_ctrl && wr_data[C_SPT]);
            end
        end
    end
endmodule

// File: rtl/relw_status.sv
// Status flags and the sticky standby state.
// Assumes that event strobes are already masked by enable and by commands. Standby
// gating of the data-phase events is done outside; match/ext gating is done here.
module relw_status
    import i2c_relw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic             cmd_rel,
    input  logic             wcan_hit,
    input  logic             glitch,
    input  logic             acc_start,
    input  logic             acc_stop,
    input  logic             acc_match,
    input  logic             ev_rw,
    input  logic             acc_ext,
    input  logic             acc_ack,
    input  logic             acc_master,
    output logic [REG_W-1:0] sta
);
    logic std_q, spd_q, mat_q, ext_q, trc_q, ack_q, mst_q, sby_q;
    logic entry_ok;

    // A match or extension code counts in standby only after a start.
    assign entry_ok = !sby_q || std_q;

    // Update the flags; later assignments in the event branch win.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_d) begin
            std_q <= 1'b0; spd_q <= 1'b0; mat_q <= 1'b0; ext_q <= 1'b0;
            trc_q <= 1'b0; ack_q <= 1'b0; mst_q <= 1'b0; sby_q <= 1'b0;
        end else if (cmd_rel) begin
            std_q <= 1'b0; mat_q <= 1'b0; ext_q <= 1'b0; trc_q <= 1'b0;
            ack_q <= 1'b0; mst_q <= 1'b0; sby_q <= 1'b1;
        end else begin
            if (glitch) std_q <= 1'b1;
            if (wcan_hit && trc_q) trc_q <= 1'b0;
            if (acc_start) begin
                std_q <= 1'b1; spd_q <= 1'b0; mat_q <= 1'b0;
                ext_q <= 1'b0; trc_q <= 1'b0;
            end
            if (acc_match && entry_ok) begin
                mat_q <= 1'b1;
                trc_q <= ev_rw;
                sby_q <= 1'b0;
            end
            if (acc_ext && entry_ok) begin
                ext_q <= 1'b1;
                sby_q <= 1'b0;
            end
            if (acc_ack)    ack_q <= 1'b1;
            if (acc_master) mst_q <= 1'b1;
            if (acc_stop) begin
                spd_q <= 1'b1; std_q <= 1'b0; mat_q <= 1'b0; ext_q <= 1'b0;
                trc_q <= 1'b0; ack_q <= 1'b0; mst_q <= 1'b0; sby_q <= 1'b0;
            end
        end
    end

    // Assemble the software view.
    always_comb begin
        sta        = '0;
        sta[S_STD] = std_q;
        sta[S_SPD] = spd_q;
        sta[S_MAT] = mat_q;
        sta[S_EXT] = ext_q;
        sta[S_TRC] = trc_q;
        sta[S_ACK] = ack_q;
        sta[S_MST] = mst_q;
        sta[S_SBY] = sby_q;
    end
endmodule

// File: rtl/relw_pad_ctrl.sv
// Open-drain pad holds: the SCL stretch at the ninth-clock wait and the SDA low hold.
// Assumes that events are already masked by enable, commands and standby.
module relw_pad_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_d,
    input  logic cmd_rel,
    input  logic wcan_hit,
    input  logic acc_wait,
    input  logic acc_data,
    input  logic acc_stop,
    output logic wait_q,
    output logic scl_oe,
    output logic sda_oe
);
    logic sda_q;

    // Set the holds from events; a release, a wait-cancel or a stop frees them.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_d || cmd_rel || wcan_hit) begin
            wait_q <= 1'b0;
            sda_q  <= 1'b0;
        end else if (acc_stop) begin
            wait_q <= 1'b0;
            sda_q  <= 1'b0;
        end else begin
            if (acc_wait) wait_q <= 1'b1;
            if (acc_data) sda_q  <= 1'b1;
        end
    end

    // Drive the pad enables straight from the holds.
    assign scl_oe = wait_q;
    assign sda_oe = sda_q;
endmodule

// File: rtl/i2c_relw_ctrl.sv
// Top of the slave release/wait control core. It qualifies bus events with the
// enable, the command cycle and standby, then feeds the register, status and pad parts.
// Assumes single-cycle event strobes from the bit engine and filtered line levels.
module i2c_relw_ctrl
    import i2c_relw_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_match,
    input  logic              ev_rw,
    input  logic              ev_ext,
    input  logic              ev_ack,
    input  logic              ev_master,
    input  logic              ev_wait,
    input  logic              ev_data,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

    logic en_q, en_d, en_rise, filt_q, stt_q, spt_q, cmd_rel, cmd_wcan;
    logic wait_q, wcan_hit, glitch, ev_ok, sby;
    logic acc_start, acc_stop, acc_match, acc_ext, acc_ack, acc_master, acc_wait, acc_data;
    logic [REG_W-1:0] sta;

    // Qualify events: enabled, no command this cycle, data-phase events also not in standby.
    always_comb begin
        sby        = sta[S_SBY];
        ev_ok      = en_q && !cmd_rel && !cmd_wcan;
        acc_start  = ev_ok && ev_start;
        acc_stop   = ev_ok && ev_stop;
        acc_match  = ev_ok && ev_match;
        acc_ext    = ev_ok && ev_ext;
        acc_ack    = ev_ok && ev_ack && !sby;
        acc_master = ev_ok && ev_master && !sby;
        acc_wait   = ev_ok && ev_wait && !sby;
        acc_data   = ev_ok && ev_data && !sby;
        wcan_hit   = cmd_wcan && wait_q;
        glitch     = en_rise && wr_data[C_FILT] && scl_in && !sda_in;
    end

    relw_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_master(acc_master), .acc_stop(acc_stop),
        .en_q(en_q), .en_d(en_d), .en_rise(en_rise), .filt_q(filt_q),
        .stt_q(stt_q), .spt_q(spt_q), .cmd_rel(cmd_rel), .cmd_wcan(cmd_wcan)
    );

    relw_status u_status (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .cmd_rel(cmd_rel), .wcan_hit(wcan_hit),
        .glitch(glitch), .acc_start(acc_start), .acc_stop(acc_stop),
        .acc_match(acc_match), .ev_rw(ev_rw), .acc_ext(acc_ext), .acc_ack(acc_ack),
        .acc_master(acc_master), .sta(sta)
    );

    relw_pad_ctrl u_pads (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .cmd_rel(cmd_rel), .wcan_hit(wcan_hit),
        .acc_wait(acc_wait), .acc_data(acc_data), .acc_stop(acc_stop),
        .wait_q(wait_q), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // Read mux; the command bits are never stored, so they read as 0.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CA) begin
            rd_data[C_EN]   = en_q;
            rd_data[C_FILT] = filt_q;
            rd_data[C_STT]  = stt_q;
            rd_data[C_SPT]  = spt_q;
        end else if (rd_addr == SA) begin
            rd_data = sta;
        end
    end
endmodule

// File: rtl/relw_chk.sv
// Assertion checker for i2c_relw_ctrl, attached by bind below.
module relw_chk
    import i2c_relw_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic              en_d,
    input logic              cmd_rel,
    input logic              cmd_wcan,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic [REG_W-1:0]  sta,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [REG_W-1:0]  rd_data
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);

    // R2
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (sta == '0 && !scl_oe && !sda_oe));

    // R3
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rel |=> (sta[S_SBY] && !sta[S_STD] && !sta[S_TRC] && !sta[S_MAT] && !scl_oe && !sda_oe));

    // R4
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CA) |-> (rd_data[C_REL] == 1'b0 && rd_data[C_WCAN] == 1'b0));

    // R7
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sta[S_SBY] |-> (!scl_oe && !sda_oe));

    // R8
    wcan_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wcan && scl_oe && sta[S_TRC]) |=> (!sta[S_TRC] && !scl_oe && !sda_oe));

    // R9
    wcan_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wcan && !cmd_rel && en_d && !scl_oe) |=> ($stable(sta) && $stable(sda_oe) && !scl_oe));
endmodule

bind i2c_relw_ctrl relw_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_relw_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_d(en_d), .cmd_rel(cmd_rel),
    .cmd_wcan(cmd_wcan), .scl_oe(scl_oe), .sda_oe(sda_oe), .sta(sta),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/i2c_relw_ctrl_bench.sv
module i2c_relw_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [0:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [0:0] rd_addr = 1'b1;
    logic [7:0] rd_data;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_match = 0, ev_rw = 0, ev_ext = 0;
    logic ev_ack = 0, ev_master = 0, ev_wait = 0, ev_data = 0;
    logic scl_oe, sda_oe;

    int total = 0;
    int bad = 0;

    // behavioural model state
    bit m_en, m_filt, m_stt, m_spt, m_std, m_spd, m_mat, m_ext, m_trc, m_ack, m_mst, m_sby;
    bit m_wait, m_sda;

    i2c_relw_ctrl u_i2c_relw_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .scl_in(scl_in), .sda_in(sda_in),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_match(ev_match), .ev_rw(ev_rw),
        .ev_ext(ev_ext), .ev_ack(ev_ack), .ev_master(ev_master), .ev_wait(ev_wait),
        .ev_data(ev_data), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_ctrl();
        return {m_en, 2'b00, m_filt, 2'b00, m_stt, m_spt};
    endfunction

    function automatic logic [7:0] exp_sta();
        return {m_sby, m_mst, m_ack, m_trc, m_ext, m_mat, m_spd, m_std};
    endfunction

    // Model of one clock edge, from the requirements.
    task automatic model_edge();
        bit wc, nen, rel, wcn, ok, hit, pass;
        wc  = wr_en && (wr_addr == 1'b0);
        nen = wc ? wr_data[7] : m_en;
        rel = wc && m_en && wr_data[6];
        wcn = wc && m_en && wr_data[5];
        ok  = m_en && !rel && !wcn;
        hit = wcn && m_wait;
        if (!nen) begin
            {m_stt, m_spt, m_std, m_spd, m_mat, m_ext, m_trc, m_ack, m_mst, m_sby, m_wait, m_sda} = '0;
        end else if (rel) begin
            {m_stt, m_spt, m_std, m_mat, m_ext, m_trc, m_ack, m_mst, m_wait, m_sda} = '0;
            m_sby = 1;
        end else begin
            bit sb, st;
            sb = m_sby; st = m_std;
            m_stt = (m_stt && !(ok && ev_master && !sb)) || (wc && wr_data[1]);
            m_spt = (m_spt && !(ok && ev_stop)) || (wc && wr_data[0]);
            if (wc && !m_en && wr_data[4] && scl_in && !sda_in) m_std = 1;
            if (hit) begin m_trc = 0; m_wait = 0; m_sda = 0; end
            if (ok && ev_start) begin m_std = 1; m_spd = 0; m_mat = 0; m_ext = 0; m_trc = 0; end
            pass = !sb || st;
            if (ok && ev_match && pass) begin m_mat = 1; m_trc = ev_rw; m_sby = 0; end
            if (ok && ev_ext && pass) begin m_ext = 1; m_sby = 0; end
            if (ok && !sb && ev_ack) m_ack = 1;
            if (ok && !sb && ev_master) m_mst = 1;
            if (ok && !sb && ev_wait) m_wait = 1;
            if (ok && !sb && ev_data) m_sda = 1;
            if (ok && ev_stop) begin
                m_spd = 1; {m_std, m_mat, m_ext, m_trc, m_ack, m_mst, m_sby, m_wait, m_sda} = '0;
            end
        end
        if (wc) begin m_en = wr_data[7]; m_filt = wr_data[4]; end
    endtask

    // Compare every output against the model.
    task automatic cycle_compare();
        chk("R8 scl_oe", {7'b0, scl_oe}, {7'b0, m_wait});
        chk("R7 sda_oe", {7'b0, sda_oe}, {7'b0, m_sda});
        chk("R3 rd_data", rd_data, rd_addr == 1'b0 ? exp_ctrl() : exp_sta());
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cycle_compare();
        {wr_en, ev_start, ev_stop, ev_match, ev_rw, ev_ext, ev_ack, ev_master, ev_wait, ev_data} = '0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_addr = 1'b0; wr_data = d;
        step();
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        rd_addr = 1'b1;
        #1;
    endtask

    task automatic oe_chk(input logic es, input logic ed, input string tag);
        chk(tag, {6'b0, scl_oe, sda_oe}, {6'b0, es, ed});
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        rd_chk(0, 8'h00, "R1 ctrl after reset");
        rd_chk(1, 8'h00, "R1 status after reset");
        oe_chk(0, 0, "R1 pads after reset");

        // R2 events and commands ignored while disabled
        ev_start = 1; step();
        rd_chk(1, 8'h00, "R2 start while disabled");
        wr(8'h40);
        rd_chk(1, 8'h00, "R2 release while disabled");

        // R10 enabling onto a start-like bus with filter on
        scl_in = 1; sda_in = 0;
        wr(8'h90);
        rd_chk(1, 8'h01, "R10 false start on enable");
        rd_chk(0, 8'h90, "R4 ctrl after enable");
        wr(8'hC0);
        sda_in = 1;
        rd_chk(0, 8'h80, "R4 release bit reads 0");
        rd_chk(1, 8'h80, "R3 release enters standby");

        // R7 standby ignores data-phase events
        ev_wait = 1; ev_data = 1; step();
        ev_ack = 1; ev_master = 1; step();
        rd_chk(1, 8'h80, "R7 standby ignores events");
        oe_chk(0, 0, "R7 standby pads free");

        // R6 match without start is ignored, with start exits
        ev_match = 1; ev_rw = 1; step();
        rd_chk(1, 8'h80, "R6 match without start");
        ev_start = 1; step();
        rd_chk(1, 8'h81, "R6 start in standby");
        ev_match = 1; ev_rw = 1; step();
        rd_chk(1, 8'h15, "R6 match after start exits");

        // R8 transmit-mode wait cancel
        ev_data = 1; ev_wait = 1; step();
        ev_ack = 1; step();
        oe_chk(1, 1, "R8 wait holds both lines");
        rd_chk(1, 8'h35, "R8 ack seen in transmit");
        wr(8'hA0);
        oe_chk(0, 0, "R8 wait-cancel frees lines");
        rd_chk(1, 8'h25, "R8 transmit flag cleared");
        rd_chk(0, 8'h80, "R4 wait-cancel bit reads 0");

        // R9 wait cancel with nothing pending
        wr(8'hA0);
        rd_chk(1, 8'h25, "R9 idle wait-cancel");
        oe_chk(0, 0, "R9 idle wait-cancel pads");

        // R5 stop ends standby
        wr(8'hC0);
        rd_chk(1, 8'h80, "R3 second release");
        ev_stop = 1; step();
        rd_chk(1, 8'h02, "R5 stop exits standby");

        // R8 receive-mode wait cancel
        ev_start = 1; step();
        ev_match = 1; ev_rw = 0; step();
        rd_chk(1, 8'h05, "R8 receive match");
        ev_data = 1; ev_wait = 1; step();
        oe_chk(1, 1, "R8 receive wait");
        wr(8'hA0);
        oe_chk(0, 0, "R8 receive wait-cancel");
        rd_chk(1, 8'h05, "R8 receive keeps flags");

        // R3 release clears request bits
        wr(8'h83);
        rd_chk(0, 8'h83, "R3 requests set");
        ev_stop = 1; wr_en = 1; wr_addr = 0; wr_data = 8'hC0; step();
        rd_chk(0, 8'h80, "R3 release clears requests");
        rd_chk(1, 8'h80, "R11 stop discarded in release cycle");

        // R6 extension code after start, R11 data masked by wait-cancel
        ev_start = 1; step();
        ev_ext = 1; step();
        rd_chk(1, 8'h09, "R6 extension code exits");
        ev_wait = 1; step();
        oe_chk(1, 0, "R11 wait before cancel");
        ev_data = 1; wr_en = 1; wr_addr = 0; wr_data = 8'hA0; step();
        oe_chk(0, 0, "R11 data discarded in cancel cycle");

        // R2 disable clears everything
        ev_wait = 1; step();
        wr(8'h00);
        rd_chk(1, 8'h00, "R2 disable clears status");
        rd_chk(0, 8'h00, "R2 disable clears ctrl");
        oe_chk(0, 0, "R2 disable frees pads");

        // R10 no false start with filter off
        sda_in = 0;
        wr(8'h80);
        rd_chk(1, 8'h00, "R10 filter off no start");
        sda_in = 1;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule